// File: doc/BRIEF.md
# Peripheral Command and Status Register Front End

This block is the register-level front end of a slow peripheral. A CPU reaches it through a simple word-wide register bus. Through that bus it can write an operation code, poll a status word, and fill or drain a small bank of buffer words. The peripheral sits on the other side and sees only a one-cycle start strobe, the operation code, and its own port into the same buffer words. It answers with a one-cycle completion strobe and an error code.

The status word carries two flags. A busy flag means an operation is in flight. A done flag means the operation has finished but software has not yet acknowledged it. Both clear means idle. While done is set, an interrupt line is held high. Software acknowledges by writing 1 to the done bit. This returns the block to idle and drops the interrupt.

A command is accepted only from idle. A command written at any other time is dropped and sets a sticky protocol-error flag. A typical write to the device follows four steps:
1. Poll until busy and done are both clear.
2. Load buffer word 0.
3. Write the command.
4. Poll until busy clears, or wait for the interrupt.

Top module: `devctl_top`

## Requirements
- R1: After reset the status word, command register and all buffer words read 0, and `irq` and `dev_start` are low.
- R2: A command write at address 0 while idle is accepted. From the next cycle the status reads busy (bit 0 = 1, bit 1 = 0). `dev_start` is high for exactly that one cycle, and `dev_op` and a read of address 0 return the written opcode (bits OP_W-1:0).
- R3: A `dev_done` strobe while busy clears busy and sets done (bit 1) from the next cycle. In that same cycle `irq` is raised and `dev_err` is latched into the device-code field (status bits ERR_W:2).
- R4: A status write (address 1) with bit 1 = 1 while done is set clears done and `irq` from the next cycle. A status write with bit 1 = 0 leaves done and `irq` unchanged.
- R5: A command write while busy or done is set is ignored: no `dev_start` pulse, and flags, `dev_op` and the command register are unchanged. It sets the sticky protocol-error flag (status bit ERR_W+1). Only a status write with 1 in that bit clears the flag, and an accepted command leaves it alone.
- R6: Busy and done are never both set.
- R7: Buffer word i is at address 2+i. The CPU can read and write it while not busy. A CPU write to a buffer word while busy is ignored.
- R8: The device port writes buffer word `dev_buf_idx` only while busy, and a device write while not busy is ignored. `dev_buf_rdata` always returns the word at `dev_buf_idx`.
- R9: A `dev_done` strobe while idle has no effect: the status and `irq` stay as they were.
- R10: An accepted command clears the device-code field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Register address: 0 command, 1 status, 2.. buffer |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Completion interrupt, held until acknowledged |
| dev_start | output | 1 | One-cycle start strobe to the peripheral |
| dev_op | output | OP_W | Operation code of the accepted command |
| dev_done | input | 1 | One-cycle completion strobe from the peripheral |
| dev_err | input | ERR_W-1 | Peripheral error code, sampled with `dev_done` |
| dev_buf_we | input | 1 | Peripheral write to a buffer word |
| dev_buf_idx | input | IDX_W | Buffer word selected by the peripheral |
| dev_buf_wdata | input | DATA_W | Peripheral write data |
| dev_buf_rdata | output | DATA_W | Buffer word at `dev_buf_idx` |

## Verification
The in-module assertions check several rules on every cycle:
- the two status flags are never both set;
- the start strobe lasts one cycle and appears only on leaving idle;
- the interrupt rises only after a completion strobe and is held until acknowledged;
- a rejected command sets the protocol flag and leaves the opcode alone;
- the buffer freezes against whichever side does not own it.

Only the directed scenarios can show the values that travel through the block. These are the opcode reaching the peripheral, the latched error code, and the data moved through the buffer in each direction. The scenarios also show that acknowledge and error clearing respond to the exact bit written, and that operation lengths from one cycle to tens of cycles behave alike.

// File: rtl/devctl_pkg.sv
`timescale 1ns/1ps
package devctl_pkg;

   // {busy, done}; the pair 2'b11 is not a member
   typedef enum logic [1:0] {
      PH_IDLE     = 2'b00,
      PH_FINISHED = 2'b01,
      PH_WORKING  = 2'b10
   } phase_e;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2,
      SEL_NONE = 2'd3
   } regsel_e;

   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_DONE_BIT = 1;
   localparam int STAT_ERR_LSB  = 2;
   localparam int BUF_BASE      = 2;

endpackage

// File: rtl/devctl_decode.sv
`timescale 1ns/1ps
module devctl_decode
   import devctl_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int NUM_DATA = 4,
   parameter int IDX_W    = 2
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output regsel_e           sel,
   output logic [IDX_W-1:0]  idx,
   output logic              cmd_we,
   output logic              stat_we,
   output logic              data_we
);

   int addr_i;

   always_comb begin
      addr_i = int'(bus_addr);
      idx    = '0;
      if (addr_i == 0) begin
         sel = SEL_CMD;
      end else if (addr_i == 1) begin
         sel = SEL_STAT;
      end else if (addr_i < BUF_BASE + NUM_DATA) begin
         sel = SEL_DATA;
         idx = IDX_W'(addr_i - BUF_BASE);
      end else begin
         sel = SEL_NONE;
      end
   end

   always_comb begin
      cmd_we  = bus_sel && bus_wr && (sel == SEL_CMD);
      stat_we = bus_sel && bus_wr && (sel == SEL_STAT);
      data_we = bus_sel && bus_wr && (sel == SEL_DATA);
   end

endmodule

// File: rtl/devctl_status.sv
`timescale 1ns/1ps
module devctl_status
   import devctl_pkg::*;
#(
   parameter int OP_W  = 4,
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [OP_W-1:0]  cmd_op,
   input  logic             ack_done,
   input  logic             clr_proto,
   input  logic             dev_done,
   input  logic [ERR_W-2:0] dev_err,
   output logic             busy,
   output logic             done,
   output logic             irq,
   output logic             proto_err,
   output logic [ERR_W-2:0] dev_code,
   output logic [OP_W-1:0]  op_q,
   output logic             start_q
);

   phase_e phase_q, phase_d;
   logic   cmd_ok, cmd_bad, finish, ack;
   logic   irq_q, proto_q;
   logic [ERR_W-2:0] code_q;

   always_comb begin
      cmd_ok  = cmd_we && (phase_q == PH_IDLE);
      cmd_bad = cmd_we && (phase_q != PH_IDLE);
      finish  = dev_done && (phase_q == PH_WORKING);
      ack     = ack_done && (phase_q == PH_FINISHED);
   end

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:     if (cmd_ok) phase_d = PH_WORKING;
         PH_WORKING:  if (finish) phase_d = PH_FINISHED;
         PH_FINISHED: if (ack)    phase_d = PH_IDLE;
         default:                 phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         irq_q   <= 1'b0;
         proto_q <= 1'b0;
         code_q  <= '0;
         op_q    <= '0;
         start_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         start_q <= cmd_ok;
         if (cmd_ok) op_q <= cmd_op;
         if (finish)   irq_q <= 1'b1;
         else if (ack) irq_q <= 1'b0;
         if (cmd_ok)      code_q <= '0;
         else if (finish) code_q <= dev_err;
         if (cmd_bad)        proto_q <= 1'b1;
         else if (clr_proto) proto_q <= 1'b0;
      end
   end

   assign busy      = phase_q[1];
   assign done      = phase_q[0];
   assign irq       = irq_q;
   assign proto_err = proto_q;
   assign dev_code  = code_q;

   // R6
   never_undefined_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R2
   start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> busy && !$past(busy) && !$past(done));

   // R2
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

   // R3
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(dev_done) && done);

   // R4
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack_done |=> irq);

   // R5
   reject_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we && (busy || done) |=> proto_err && $stable(op_q) && !start_q);

   // R9
   stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_done && !busy && !done |=> !done && !irq);

endmodule

// File: rtl/devctl_buffer.sv
`timescale 1ns/1ps
module devctl_buffer #(
   parameter int DATA_W   = 32,
   parameter int NUM_DATA = 4,
   parameter int IDX_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              cpu_we,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              dev_we,
   input  logic [IDX_W-1:0]  dev_idx,
   input  logic [DATA_W-1:0] dev_wdata,
   output logic [DATA_W-1:0] dev_rdata
);

   logic [NUM_DATA-1:0][DATA_W-1:0] mem_q;

   for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
      logic dev_hit, cpu_hit;
      assign dev_hit = busy  && dev_we && (int'(dev_idx) == i);
      assign cpu_hit = !busy && cpu_we && (int'(cpu_idx) == i);

      always_ff @(posedge clk) begin
         if (!rst_n)       mem_q[i] <= '0;
         else if (dev_hit) mem_q[i] <= dev_wdata;
         else if (cpu_hit) mem_q[i] <= cpu_wdata;
      end
   end

   always_comb begin
      cpu_rdata = '0;
      dev_rdata = '0;
      for (int i = 0; i < NUM_DATA; i++) begin
         if (int'(cpu_idx) == i) cpu_rdata = mem_q[i];
         if (int'(dev_idx) == i) dev_rdata = mem_q[i];
      end
   end

   // R7
   cpu_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cpu_we && !dev_we |=> $stable(mem_q));

   // R8
   dev_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && dev_we && !cpu_we |=> $stable(mem_q));

endmodule

// File: rtl/devctl_top.sv
`timescale 1ns/1ps
module devctl_top
   import devctl_pkg::*;
#(
   parameter  int DATA_W   = 32,
   parameter  int NUM_DATA = 4,
   parameter  int OP_W     = 4,
   parameter  int ERR_W    = 4,
   localparam int ADDR_W   = $clog2(NUM_DATA + BUF_BASE),
   localparam int IDX_W    = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              dev_start,
   output logic [OP_W-1:0]   dev_op,
   input  logic              dev_done,
   input  logic [ERR_W-2:0]  dev_err,
   input  logic              dev_buf_we,
   input  logic [IDX_W-1:0]  dev_buf_idx,
   input  logic [DATA_W-1:0] dev_buf_wdata,
   output logic [DATA_W-1:0] dev_buf_rdata
);

   localparam int PROTO_BIT = STAT_ERR_LSB + ERR_W - 1;

   if (NUM_DATA < 1) begin : g_bad_depth
      $error("devctl_top: NUM_DATA must be at least 1");
   end
   if (ERR_W < 2) begin : g_bad_err
      $error("devctl_top: ERR_W must be at least 2");
   end
   if (OP_W < 1 || OP_W > DATA_W) begin : g_bad_op
      $error("devctl_top: OP_W must lie in 1..DATA_W");
   end
   if (DATA_W < PROTO_BIT + 1) begin : g_bad_data
      $error("devctl_top: DATA_W too narrow for the status word");
   end

   regsel_e          sel;
   logic [IDX_W-1:0] cpu_idx;
   logic             cmd_we, stat_we, data_we;
   logic             busy, done, proto_err;
   logic [ERR_W-2:0] dev_code;
   logic [OP_W-1:0]  op_q;
   logic [DATA_W-1:0] buf_rdata, stat_word;

   devctl_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_DATA(NUM_DATA),
      .IDX_W   (IDX_W)
   ) i_decode (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .sel     (sel),
      .idx     (cpu_idx),
      .cmd_we  (cmd_we),
      .stat_we (stat_we),
      .data_we (data_we)
   );

   devctl_status #(
      .OP_W (OP_W),
      .ERR_W(ERR_W)
   ) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_op   (bus_wdata[OP_W-1:0]),
      .ack_done (stat_we && bus_wdata[STAT_DONE_BIT]),
      .clr_proto(stat_we && bus_wdata[PROTO_BIT]),
      .dev_done (dev_done),
      .dev_err  (dev_err),
      .busy     (busy),
      .done     (done),
      .irq      (irq),
      .proto_err(proto_err),
      .dev_code (dev_code),
      .op_q     (op_q),
      .start_q  (dev_start)
   );

   devctl_buffer #(
      .DATA_W  (DATA_W),
      .NUM_DATA(NUM_DATA),
      .IDX_W   (IDX_W)
   ) i_buffer (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .cpu_we   (data_we),
      .cpu_idx  (cpu_idx),
      .cpu_wdata(bus_wdata),
      .cpu_rdata(buf_rdata),
      .dev_we   (dev_buf_we),
      .dev_idx  (dev_buf_idx),
      .dev_wdata(dev_buf_wdata),
      .dev_rdata(dev_buf_rdata)
   );

   always_comb begin
      stat_word = '0;
      stat_word[STAT_BUSY_BIT] = busy;
      stat_word[STAT_DONE_BIT] = done;
      stat_word[STAT_ERR_LSB +: ERR_W-1] = dev_code;
      stat_word[PROTO_BIT] = proto_err;
   end

   always_comb begin
      unique case (sel)
         SEL_CMD:  bus_rdata = DATA_W'(op_q);
         SEL_STAT: bus_rdata = stat_word;
         SEL_DATA: bus_rdata = buf_rdata;
         default:  bus_rdata = '0;
      endcase
   end

   assign dev_op = op_q;

   // R3
   code_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> dev_code == $past(dev_err));

   // R10
   code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_start |-> dev_code == '0);

endmodule

// File: tb/test_devctl_top.sv
`timescale 1ns/1ps
module test_devctl_top;

   localparam int DATA_W = 32;
   localparam int NUM_DATA = 4;
   localparam int OP_W = 4;
   localparam int ERR_W = 4;
   localparam int ADDR_W = 3;
   localparam int IDX_W = 2;
   localparam logic [31:0] PROTO = 32'h20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
   logic irq, dev_start;
   logic [OP_W-1:0] dev_op;
   logic dev_done = 1'b0;
   logic [ERR_W-2:0] dev_err = '0;
   logic dev_buf_we = 1'b0;
   logic [IDX_W-1:0] dev_buf_idx = '0;
   logic [DATA_W-1:0] dev_buf_wdata = '0, dev_buf_rdata;

   int checks = 0;
   int fails = 0;

   always #10ns clk = ~clk;

   devctl_top #(.DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .OP_W(OP_W), .ERR_W(ERR_W)) i_devctl_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .dev_start(dev_start), .dev_op(dev_op),
      .dev_done(dev_done), .dev_err(dev_err), .dev_buf_we(dev_buf_we),
      .dev_buf_idx(dev_buf_idx), .dev_buf_wdata(dev_buf_wdata),
      .dev_buf_rdata(dev_buf_rdata));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1;
      bus_addr = ADDR_W'(addr); bus_wdata = data;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int addr, output logic [31:0] data);
      bus_addr = ADDR_W'(addr);
      #1ns;
      data = bus_rdata;
   endtask

   task automatic check_reg(input string req, input int addr, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(addr, v);
      check(req, v, exp);
   endtask

   task automatic finish_op(input int lat, input logic [ERR_W-2:0] code);
      repeat (lat) @(negedge clk);
      dev_done = 1'b1; dev_err = code;
      @(negedge clk);
      dev_done = 1'b0; dev_err = '0;
   endtask

   // R1
   task automatic t_reset();
      check_reg("R1 status", 1, 32'h0);
      check_reg("R1 command", 0, 32'h0);
      for (int i = 0; i < NUM_DATA; i++) check_reg("R1 buffer", 2 + i, 32'h0);
      check("R1 irq", irq, 1'b0);
      check("R1 dev_start", dev_start, 1'b0);
   endtask

   task automatic t_write_op();
      bus_write(2, 32'hA5A5_0001);
      check_reg("R7 buffer word 0", 2, 32'hA5A5_0001);
      bus_write(0, 32'h3);
      check("R2 dev_start high", dev_start, 1'b1);
      check("R2 dev_op", dev_op, 4'h3);
      check_reg("R2 busy status", 1, 32'h1);
      check_reg("R2 command readback", 0, 32'h3);
      dev_buf_idx = 0;
      #1ns;
      check("R8 device reads buffer", dev_buf_rdata, 32'hA5A5_0001);
      @(negedge clk);
      check("R2 dev_start one cycle", dev_start, 1'b0);
      finish_op(3, 3'd0);
      check_reg("R3 finished status", 1, 32'h2);
      check("R3 irq raised", irq, 1'b1);
      bus_write(1, 32'h0);
      check_reg("R4 zero write keeps done", 1, 32'h2);
      check("R4 zero write keeps irq", irq, 1'b1);
      bus_write(1, 32'h2);
      check_reg("R4 ack returns idle", 1, 32'h0);
      check("R4 ack drops irq", irq, 1'b0);
   endtask

   task automatic t_reject();
      bus_write(0, 32'h5);
      @(negedge clk);
      bus_write(0, 32'h7);
      check("R5 no start while busy", dev_start, 1'b0);
      check("R5 op kept", dev_op, 4'h5);
      check_reg("R5 busy plus proto", 1, PROTO | 32'h1);
      check_reg("R5 command kept", 0, 32'h5);
      bus_write(3, 32'hDEAD_BEEF);
      check_reg("R7 cpu write while busy ignored", 3, 32'h0);
      check_reg("R6 flags never both", 1, PROTO | 32'h1);
      finish_op(7, 3'd5);
      check_reg("R3 error code latched", 1, PROTO | (32'd5 << 2) | 32'h2);
      bus_write(0, 32'h9);
      check("R5 no start while done", dev_start, 1'b0);
      check_reg("R5 done command ignored", 1, PROTO | (32'd5 << 2) | 32'h2);
      bus_write(1, 32'h2);
      check_reg("R5 proto survives ack", 1, PROTO | (32'd5 << 2));
      bus_write(1, PROTO);
      check_reg("R5 proto cleared", 1, 32'd5 << 2);
      bus_write(1, PROTO);
      bus_write(0, 32'h9);
      check_reg("R10 code cleared on start", 1, 32'h1);
      finish_op(1, 3'd0);
      bus_write(1, 32'h2);
      bus_write(0, 32'h4);
      bus_write(1, PROTO);
      check_reg("R5 accepted command leaves proto", 1, 32'h1);
      finish_op(0, 3'd0);
      bus_write(1, 32'h2);
   endtask

   task automatic t_read_op();
      bus_write(0, 32'h2);
      for (int i = 1; i < NUM_DATA; i++) begin
         @(negedge clk);
         dev_buf_we = 1'b1; dev_buf_idx = IDX_W'(i); dev_buf_wdata = 32'h100 + i;
      end
      @(negedge clk);
      dev_buf_we = 1'b0;
      finish_op(2, 3'd1);
      check_reg("R3 code 1", 1, (32'd1 << 2) | 32'h2);
      bus_write(1, 32'h2);
      for (int i = 1; i < NUM_DATA; i++) check_reg("R8 device data in buffer", 2 + i, 32'h100 + i);
      @(negedge clk);
      dev_buf_we = 1'b1; dev_buf_idx = 0; dev_buf_wdata = 32'h1234;
      @(negedge clk);
      dev_buf_we = 1'b0;
      check_reg("R8 device write while idle ignored", 2, 32'hA5A5_0001);
   endtask

   // R9
   task automatic t_stray_done();
      finish_op(0, 3'd3);
      check_reg("R9 stray done status", 1, 32'd1 << 2);
      check("R9 stray done irq", irq, 1'b0);
   endtask

   task automatic t_latency(input int lat);
      bus_write(0, 32'hC);
      repeat (lat) begin
         check_reg("R3 busy until done", 1, 32'h1);
         check("R3 no irq while busy", irq, 1'b0);
         @(negedge clk);
      end
      dev_done = 1'b1;
      @(negedge clk);
      dev_done = 1'b0;
      check_reg("R3 finished after latency", 1, 32'h2);
      bus_write(1, 32'h2);
      check_reg("R4 idle after ack", 1, 32'h0);
   endtask

   initial begin
      #(20ns * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_op();
      t_reject();
      t_read_op();
      t_stray_done();
      t_latency(1);
      t_latency(5);
      t_latency(20);
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule